// File: doc/BRIEF.md
# Prioritised Multi-Context Interrupt Router

This block collects level or edge interrupt requests from a set of peripheral sources and routes them to several processor contexts. Software sets a priority for each source, and for each context an enable mask and a priority threshold. Each context has its own interrupt line. That line is high while at least one pending source is enabled for the context and has a priority strictly above the context's threshold.

Software services an interrupt in two steps. A read of the context's claim/complete word returns the winning source ID. That read also moves the source from pending to in service. A later write of the same ID to the same word releases the source, so its gateway can forward a new request. Source ID 0 is reserved and means that nothing is eligible.

Access is through a simple single-cycle 32-bit register port. Read data appears one cycle after the request. The trigger style of each source is chosen by a static mode input.

Top module: `irq_router`

## Requirements
- R1: After reset, all priorities, enable bits and thresholds are 0, no source is pending, every interrupt line is low, and register reads return 0.
- R2: The priority of source N is a 3-bit field in bits 2:0 of the word at byte offset 4*N (N = 1..31). Upper write bits are dropped. A source with priority 0 never raises any line.
- R3: The enable mask of context C is at byte offset 0x2000 + 0x80*C. Source N maps to word N/32, bit N%32. Bit 0 always reads 0.
- R4: The threshold of context C is bits 2:0 at offset 0x200000 + 0x1000*C and reads back as written. Threshold 7 blocks every source.
- R5: irq_o[C] is high exactly when some pending source is enabled in C and has a priority above C's threshold.
- R6: A read of offset 0x200004 + 0x1000*C returns, on rdata_o in the next cycle, the ID of the eligible source with the highest priority. Ties go to the lowest ID. The read clears that source's pending bit and puts it in service.
- R7: A claim read when nothing is eligible returns 0 and changes no state.
- R8: A source in service does not become pending again, whatever its input does, until a completion is accepted. A completion is a write of its ID to a claim/complete word.
- R9: A completion is ignored if the ID is out of range, the source is not in service, or the source's enable bit is clear in the writing context.
- R10: In level mode (edge_mode_i bit = 0), a high input makes the source pending. When a completion is accepted, the source becomes pending again if its input is high in that cycle.
- R11: In edge mode (edge_mode_i bit = 1), a rising input edge makes an idle source pending. One rising edge seen while in service is held and turns into a pending request at completion. Further edges in that interval, and edges while already pending, are merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC (bits NUM_SRC:1) | Interrupt request from each source |
| edge_mode_i | input | NUM_SRC (bits NUM_SRC:1) | Per-source trigger style: 1 edge, 0 level |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request, 0 otherwise |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
Several sources are held high together at equal and at different priorities. This separates ordering by priority from the lowest-ID tie rule, and shows whether one claim removes a shared source from a second context. Thresholds are moved across a source's priority, and priority is set to zero, to find any off-by-one in the strict comparison. Edge sources get pulse trains during service, and level sources are held high or dropped across completion, to tell buffered, merged and re-raised requests apart. Completions are also sent from a context with the source disabled, and while the source is idle, to prove that those writes leave the in-service state untouched.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [11:0] THR_OFS    = 12'h000;
  localparam logic [11:0] CLAIM_OFS  = 12'h004;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } acc_e;
endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26,
  localparam int SRC_W    = $clog2(NUM_SRC + 1),
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int EN_WORDS = (NUM_SRC + 32) / 32,
  localparam int WORD_W   = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [31:0] EN_END  = EN_BASE + EN_STRIDE * 32'(NUM_CTX);
  localparam logic [31:0] CTX_END = CTX_BASE + CTX_STRIDE * 32'(NUM_CTX);

  logic [31:0] a, off, idx;

  always_comb begin
    a      = 32'(addr_i);
    idx    = {2'b00, a[31:2]};
    off    = '0;
    kind_o = ACC_NONE;
    src_o  = '0;
    ctx_o  = '0;
    word_o = '0;
    if (a[1:0] == 2'b00) begin
      if (a < EN_BASE) begin
        if (idx != 32'd0 && idx <= 32'(NUM_SRC)) begin
          kind_o = ACC_PRIO;
          src_o  = SRC_W'(idx);
        end
      end else if (a < EN_END) begin
        off   = a - EN_BASE;
        ctx_o = CTX_W'(off >> 7);
        if (32'(off[6:2]) < 32'(EN_WORDS)) begin
          kind_o = ACC_EN;
          word_o = WORD_W'(off[6:2]);
        end
      end else if (a >= CTX_BASE && a < CTX_END) begin
        off   = a - CTX_BASE;
        ctx_o = CTX_W'(off >> 12);
        if (off[11:0] == THR_OFS)        kind_o = ACC_THR;
        else if (off[11:0] == CLAIM_OFS) kind_o = ACC_CLAIM;
      end
    end
  end
endmodule

// File: rtl/irq_router_gw.sv
module irq_router_gw (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o
);
  logic pend_q, svc_q, held_q, src_q;
  logic pend_d, svc_d, held_d;
  logic rise, trig;

  assign rise = src_i & ~src_q;
  assign trig = edge_i ? rise : src_i;

  always_comb begin
    pend_d = pend_q;
    svc_d  = svc_q;
    held_d = held_q;
    if (claim_i) begin
      pend_d = 1'b0;
      svc_d  = 1'b1;
      held_d = held_q | (edge_i & rise);
    end else if (done_i && svc_q) begin
      svc_d  = 1'b0;
      pend_d = held_q | trig;   // level: re-raise if still high
      held_d = 1'b0;
    end else begin
      if (!svc_q && !pend_q && trig) pend_d = 1'b1;
      if (svc_q && edge_i && rise)   held_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
      held_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
      held_q <= held_d;
      src_q  <= src_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  localparam int SRC_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]             pend_i,
  input  logic [NUM_SRC:1]             en_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [SRC_W-1:0]             id_o,
  output logic                         irq_o
);
  logic [PRIO_W-1:0] best;
  logic              hit;

  // Scan from the top ID down; >= lets a lower ID take over a tie.
  always_comb begin
    best = '0;
    hit  = 1'b0;
    id_o = '0;
    for (int s = NUM_SRC; s >= 1; s--) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > thr_i) &&
          (!hit || prio_i[s] >= best)) begin
        hit  = 1'b1;
        best = prio_i[s];
        id_o = SRC_W'(s);
      end
    end
    irq_o = hit;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC:1]   src_i,
  input  logic [NUM_SRC:1]   edge_mode_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int SRC_W    = $clog2(NUM_SRC + 1);
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;
  localparam int WORD_W   = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;

  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:1] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC:1]              pend, claim_pulse, done_pulse;
  logic [NUM_CTX-1:0][SRC_W-1:0] win_id;
  logic [31:0]                   rd_val, rdata_q;

  acc_e              dec_kind;
  logic [SRC_W-1:0]  dec_src;
  logic [CTX_W-1:0]  dec_ctx;
  logic [WORD_W-1:0] dec_word;
  logic              rd_en, wr_en;

  assign rd_en = req_i & ~we_i;
  assign wr_en = req_i &  we_i;

  irq_router_decode #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr_i (addr_i),
    .kind_o (dec_kind),
    .src_o  (dec_src),
    .ctx_o  (dec_ctx),
    .word_o (dec_word)
  );

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gw
    irq_router_gw u_gw (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[s]),
      .edge_i  (edge_mode_i[s]),
      .claim_i (claim_pulse[s]),
      .done_i  (done_pulse[s]),
      .pend_o  (pend[s])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    irq_router_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .pend_i (pend),
      .en_i   (en_q[c]),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .id_o   (win_id[c]),
      .irq_o  (irq_o[c])
    );
  end

  // Claim and completion strobes to the gateways
  always_comb begin
    for (int s = 1; s <= NUM_SRC; s++) begin
      claim_pulse[s] = rd_en && (dec_kind == ACC_CLAIM) &&
                       (win_id[dec_ctx] == SRC_W'(s));
      done_pulse[s]  = wr_en && (dec_kind == ACC_CLAIM) &&
                       (wdata_i == 32'(s)) && en_q[dec_ctx][s];
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (dec_kind)
      ACC_PRIO:  rd_val = 32'(prio_q[dec_src]);
      ACC_EN: begin
        for (int s = 1; s <= NUM_SRC; s++)
          if (s / 32 == int'(dec_word)) rd_val[s % 32] = en_q[dec_ctx][s];
      end
      ACC_THR:   rd_val = 32'(thr_q[dec_ctx]);
      ACC_CLAIM: rd_val = 32'(win_id[dec_ctx]);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_en ? rd_val : 32'd0;
      if (wr_en) begin
        unique case (dec_kind)
          ACC_PRIO: prio_q[dec_src] <= wdata_i[PRIO_W-1:0];
          ACC_EN: begin
            for (int s = 1; s <= NUM_SRC; s++)
              if (s / 32 == int'(dec_word)) en_q[dec_ctx][s] <= wdata_i[s % 32];
          end
          ACC_THR:  thr_q[dec_ctx] <= wdata_i[PRIO_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [31:0]                   rdata_o,
  input logic [NUM_CTX-1:0]            irq_o,
  input logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q,
  input logic [NUM_SRC:1]              pend,
  input logic [NUM_SRC:1]              claim_pulse
);
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    localparam logic [31:0] CLM_ADDR = CTX_BASE + CTX_STRIDE * 32'(c) + 32'(CLAIM_OFS);
    logic claim_rd;
    assign claim_rd = req_i && !we_i && (32'(addr_i) == CLM_ADDR);

    AST_CLAIM_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_rd && !irq_o[c] |=> rdata_o == 32'd0); // R7
    AST_CLAIM_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_rd && !irq_o[c] |-> claim_pulse == '0); // R7
    AST_CLAIM_BUSY_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_rd && irq_o[c] |=> (rdata_o != 32'd0 && rdata_o <= 32'(NUM_SRC))); // R6
    AST_THR_TOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&thr_q[c]) |-> !irq_o[c]); // R4
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    AST_CLAIM_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_pulse[s] |=> !pend[s]); // R6
  end

  AST_ONE_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_pulse)); // R6
endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .thr_q       (thr_q),
  .pend        (pend),
  .claim_pulse (claim_pulse)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NS = 31;
  localparam int NC = 2;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS:1]   src = '0;
  logic [NS:1]   edge_mode = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .edge_mode_i(edge_mode),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_prio [1:NS];
  bit m_en   [0:NC-1][1:NS];
  int m_thr  [0:NC-1];
  bit m_pend [1:NS];
  bit m_svc  [1:NS];
  bit m_held [1:NS];
  bit m_prev [1:NS];
  int m_rdata = 0;

  function automatic int winner(int c);
    int best = 0;
    int bp = 0;
    for (int s = 1; s <= NS; s++)
      if (m_pend[s] && m_en[c][s] && m_prio[s] > m_thr[c] && m_prio[s] > bp) begin
        best = s;
        bp = m_prio[s];
      end
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= NS; s++) begin
        m_prio[s] = 0; m_pend[s] = 0; m_svc[s] = 0; m_held[s] = 0; m_prev[s] = 0;
        for (int c = 0; c < NC; c++) m_en[c][s] = 0;
      end
      for (int c = 0; c < NC; c++) m_thr[c] = 0;
      m_rdata = 0;
    end else begin
      int a, rv, claim_id, done_id, kind, ctx, wrd;
      a = int'(addr);
      rv = 0; claim_id = 0; done_id = 0; kind = 0; ctx = 0; wrd = 0;
      if (a % 4 == 0) begin
        if (a < 'h2000 && a / 4 >= 1 && a / 4 <= NS) kind = 1;
        else if (a >= 'h2000 && a < 'h2000 + 'h80 * NC) begin
          ctx = (a - 'h2000) / 'h80; wrd = ((a - 'h2000) % 'h80) / 4;
          if (wrd * 32 <= NS) kind = 2;
        end else if (a >= 'h200000 && a < 'h200000 + 'h1000 * NC) begin
          ctx = (a - 'h200000) / 'h1000;
          if ((a - 'h200000) % 'h1000 == 0) kind = 3;
          if ((a - 'h200000) % 'h1000 == 4) kind = 4;
        end
      end
      if (req && !we) begin
        case (kind)
          1: rv = m_prio[a / 4];
          2: for (int s = 1; s <= NS; s++) if (s / 32 == wrd && m_en[ctx][s]) rv = rv | (1 << (s % 32));
          3: rv = m_thr[ctx];
          4: begin rv = winner(ctx); claim_id = rv; end
          default: rv = 0;
        endcase
      end
      if (req && we && kind == 4 && wdata >= 1 && wdata <= NS && m_en[ctx][int'(wdata)])
        done_id = int'(wdata);
      for (int s = 1; s <= NS; s++) begin
        bit rise, trig;
        rise = src[s] && !m_prev[s];
        trig = edge_mode[s] ? rise : src[s];
        if (claim_id == s) begin
          m_pend[s] = 0; m_svc[s] = 1;
          if (edge_mode[s] && rise) m_held[s] = 1;
        end else if (done_id == s && m_svc[s]) begin
          m_svc[s] = 0; m_pend[s] = m_held[s] || trig; m_held[s] = 0;
        end else begin
          if (!m_svc[s] && !m_pend[s] && trig) m_pend[s] = 1;
          if (m_svc[s] && edge_mode[s] && rise) m_held[s] = 1;
        end
        m_prev[s] = src[s];
      end
      if (req && we) begin
        case (kind)
          1: m_prio[a / 4] = int'(wdata & 32'h7);
          2: for (int s = 1; s <= NS; s++) if (s / 32 == wrd) m_en[ctx][s] = wdata[s % 32];
          3: m_thr[ctx] = int'(wdata & 32'h7);
          default: ;
        endcase
      end
      m_rdata = rv;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare DUT with the model on every cycle
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NC; c++)
        chk("R5 irq line vs model", 32'(irq[c]), 32'(winner(c) != 0));
      chk("R6 read data vs model", rdata, 32'(m_rdata));
    end
  end

  // ---------------- bus and stimulus helpers ----------------
  function automatic logic [31:0] a_prio(int s); return 32'(4 * s); endfunction
  function automatic logic [31:0] a_en(int c);   return 32'('h2000 + 'h80 * c); endfunction
  function automatic logic [31:0] a_thr(int c);  return 32'('h200000 + 'h1000 * c); endfunction
  function automatic logic [31:0] a_clm(int c);  return 32'('h200004 + 'h1000 * c); endfunction

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src[s] = 1'b1;
    @(negedge clk); src[s] = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired before R11 sequence finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    edge_mode[9] = 1'b1;
    idle(3);
    rst_n = 1'b1;
    running = 1;
    idle(1);

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    bus_rd(a_prio(5), d);  chk("R1 priority after reset", d, 32'd0);
    bus_rd(a_en(1), d);    chk("R1 enable after reset", d, 32'd0);
    bus_rd(a_thr(0), d);   chk("R1 threshold after reset", d, 32'd0);
    bus_rd(a_clm(0), d);   chk("R7 empty claim", d, 32'd0);

    // R2 priorities
    bus_wr(a_prio(3), 2); bus_wr(a_prio(5), 5); bus_wr(a_prio(7), 5); bus_wr(a_prio(9), 1);
    bus_rd(a_prio(5), d);  chk("R2 priority readback", d, 32'd5);
    bus_wr(a_prio(11), 32'hFF);
    bus_rd(a_prio(11), d); chk("R2 priority width", d, 32'd7);
    bus_wr(a_prio(11), 0);

    // R3 enables
    bus_wr(a_en(0), 32'hA9);
    bus_rd(a_en(0), d);    chk("R3 enable bit0 zero", d, 32'hA8);
    bus_wr(a_en(1), 32'h208);
    bus_rd(a_en(1), d);    chk("R3 enable ctx1", d, 32'h208);

    // R5/R6 level sources, tie on priority 5
    src[3] = 1'b1; src[5] = 1'b1; src[7] = 1'b1;
    idle(2);
    chk("R5 both lines", 32'(irq), 32'd3);
    bus_rd(a_clm(0), d);   chk("R6 tie lowest id", d, 32'd5);
    bus_rd(a_clm(0), d);   chk("R6 next winner", d, 32'd7);
    bus_rd(a_clm(0), d);   chk("R6 lower priority last", d, 32'd3);
    chk("R6 shared source removed from ctx1", 32'(irq), 32'd0);
    bus_rd(a_clm(0), d);   chk("R7 nothing eligible", d, 32'd0);
    idle(2);
    chk("R8 held in service", 32'(irq), 32'd0);

    // R9 completion from a context without the enable
    bus_wr(a_clm(1), 5);
    idle(2);
    chk("R9 foreign completion ignored", 32'(irq), 32'd0);

    // R10 level re-raise
    bus_wr(a_clm(0), 5);
    chk("R10 re-raised while high", 32'(irq[0]), 32'd1);
    bus_rd(a_clm(0), d);   chk("R10 reclaim", d, 32'd5);
    src[5] = 1'b0;
    bus_wr(a_clm(0), 5);
    idle(2);
    chk("R10 no re-raise when low", 32'(irq), 32'd0);
    src[3] = 1'b0; src[7] = 1'b0;
    bus_wr(a_clm(0), 7); bus_wr(a_clm(0), 3);
    idle(1);
    chk("R8 completions settle", 32'(irq), 32'd0);

    // R4 thresholds
    src[5] = 1'b1;
    idle(2);
    chk("R4 threshold 0", 32'(irq[0]), 32'd1);
    bus_wr(a_thr(0), 5);   chk("R4 equal blocks", 32'(irq[0]), 32'd0);
    bus_wr(a_thr(0), 4);   chk("R4 below passes", 32'(irq[0]), 32'd1);
    bus_rd(a_thr(0), d);   chk("R4 readback", d, 32'd4);
    bus_wr(a_prio(5), 7); bus_wr(a_thr(0), 7);
    chk("R4 max blocks", 32'(irq[0]), 32'd0);
    bus_wr(a_thr(0), 0);
    bus_rd(a_clm(0), d);   chk("R6 claim after threshold", d, 32'd5);
    src[5] = 1'b0;
    bus_wr(a_clm(0), 5);

    // R2 priority 0 masks
    bus_wr(a_prio(3), 0);
    src[3] = 1'b1;
    idle(2);
    chk("R2 zero priority masks", 32'(irq), 32'd0);
    src[3] = 1'b0;
    bus_wr(a_prio(3), 2);
    chk("R5 masked pending appears", 32'(irq), 32'd3);
    bus_rd(a_clm(1), d);   chk("R6 claim ctx1", d, 32'd3);
    bus_wr(a_clm(1), 3);
    idle(1);
    chk("R8 ctx1 completion", 32'(irq), 32'd0);

    // R11 edge source 9 in ctx1
    pulse(9); idle(1);
    chk("R11 edge pending", 32'(irq[1]), 32'd1);
    bus_rd(a_clm(1), d);   chk("R11 edge claim", d, 32'd9);
    pulse(9); pulse(9); idle(1);
    chk("R8 edge held in service", 32'(irq[1]), 32'd0);
    bus_wr(a_clm(1), 9);
    chk("R11 buffered edge", 32'(irq[1]), 32'd1);
    bus_rd(a_clm(1), d);   chk("R11 buffered claim", d, 32'd9);
    bus_wr(a_clm(1), 9);
    idle(1);
    chk("R11 extra edges merged", 32'(irq[1]), 32'd0);
    bus_rd(a_clm(1), d);   chk("R11 nothing left", d, 32'd0);
    src[9] = 1'b1; idle(2);
    bus_rd(a_clm(1), d);   chk("R11 high input claim", d, 32'd9);
    bus_wr(a_clm(1), 9);
    idle(2);
    chk("R11 steady high no retrigger", 32'(irq[1]), 32'd0);
    src[9] = 1'b0;

    // R9 disabled source cannot complete
    pulse(9); idle(1);
    bus_rd(a_clm(1), d);   chk("R9 claim before disable", d, 32'd9);
    bus_wr(a_en(1), 32'h008);
    bus_wr(a_clm(1), 9);
    bus_wr(a_en(1), 32'h208);
    pulse(9); idle(1);
    chk("R9 still in service", 32'(irq[1]), 32'd0);
    bus_wr(a_clm(1), 9);
    chk("R9 completion after re-enable", 32'(irq[1]), 32'd1);
    bus_rd(a_clm(1), d);   chk("R9 reclaim", d, 32'd9);
    bus_wr(a_clm(1), 9);
    idle(2);

    running = 0;
    finished = 1;
    summary();
    $finish;
  end
endmodule